// File: doc/BRIEF.md
# Bank Conflict Pass Scheduler

This block takes one group of word addresses from a set of parallel lanes and works out how a banked, word-interleaved memory would serve them. Each lane has an active bit. Each active lane's address picks a bank, and the block splits the group into a sequence of serialized passes. Lanes that ask for the same word in a bank are served together in one pass, because that word is broadcast to all of them. Lanes that ask for different words in the same bank must wait for separate passes.

A group is offered with a valid/ready handshake. Once a group is taken, the block produces one grant mask per cycle, one cycle for each pass. The mask says which lanes are served in that pass. The output also carries the pass index, the total pass count and a flag on the final pass. The next group is taken only after the final pass.

The lane count, bank count (16 by default, 32 also allowed, always a power of two) and address width are parameters.

Top module: `bank_pass_sched`

## Requirements
- R1: The bank of a lane is its word address modulo BANKS, which is the low log2(BANKS) address bits. Addresses that differ by a multiple of BANKS fall in the same bank.
- R2: While reset is high and in the first cycle after it, req_ready is 1 and gnt_valid is 0.
- R3: A group is taken on a rising edge where req_valid and req_ready are both 1. The first pass appears with gnt_valid=1 and gnt_pass_idx=0 in the very next cycle. req_ready stays 0 for as long as gnt_valid is 1.
- R4: The number of passes equals the largest number of distinct words requested in any one bank by active lanes, with a minimum of 1. gnt_valid stays high for exactly that many consecutive cycles, and gnt_passes shows that number during every pass.
- R5: In each pass, every bank serves the word requested by the lowest-numbered lane in that bank that has not yet been served. Every unserved lane requesting that same word is granted in the same pass (broadcast).
- R6: Across the passes of one group, each active lane is granted exactly once, and no lane appears in two grant masks.
- R7: Inactive lanes are never granted. A group with no active lane completes in one pass with an all-zero grant mask and gnt_last=1.
- R8: gnt_pass_idx counts 0, 1, 2, ... over the passes of a group. gnt_last is 1 exactly in the pass where gnt_pass_idx equals gnt_passes-1.
- R9: A group whose active addresses are consecutive words, or use a stride coprime with BANKS (for example 19 with 16 banks), completes in a single pass that grants every active lane.
- R10: A request offered while a group is being served is not taken: the grant sequence of the current group is unchanged by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request group is offered |
| req_ready | output | 1 | The block can take a group this cycle |
| req_active | input | LANES | Per-lane active bit |
| req_addr | input | LANES*ADDR_W | Word addresses; lane i occupies bits [i*ADDR_W +: ADDR_W] |
| gnt_valid | output | 1 | A pass is being reported this cycle |
| gnt_mask | output | LANES | Lanes served in this pass |
| gnt_last | output | 1 | This is the final pass of the group |
| gnt_pass_idx | output | $clog2(LANES+1) | Index of the current pass, starting at 0 |
| gnt_passes | output | $clog2(LANES+1) | Total number of passes for the group |

## Verification
The bench goes after these cases:
- All lanes on one word. A design without broadcast would take sixteen passes instead of one.
- A stride equal to the bank count. This yields sixteen passes that must come in lane order; getting the serving order wrong reorders the masks.
- A stride of 19 and consecutive addresses. These must take one pass; a wrong bank mapping would add passes.
- An all-inactive group, a conflicting inactive lane, and a mixed case of three words in one bank shared by pairs of lanes. These expose designs that grant idle lanes, drop broadcast partners or miscount passes.
- A fresh request held high during a busy group. It must not disturb that group's grants, which catches a ready that is open too early.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

    localparam int unsigned DEF_LANES  = 16;
    localparam int unsigned DEF_BANKS  = 16;
    localparam int unsigned DEF_ADDR_W = 16;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SERVE = 1'b1
    } bpc_state_e;

    // Width needed to hold a count from 0 up to n inclusive.
    function automatic int unsigned count_width(input int unsigned n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/bpc_pass_count.sv
// Works out how many passes a group needs: the worst-case number of
// distinct words landing in one bank, never less than one.
module bpc_pass_count #(
    parameter int unsigned LANES  = bpc_pkg::DEF_LANES,
    parameter int unsigned BANKS  = bpc_pkg::DEF_BANKS,
    parameter int unsigned ADDR_W = bpc_pkg::DEF_ADDR_W,
    parameter int unsigned PW     = bpc_pkg::count_width(LANES)
) (
    input  logic [LANES-1:0]        active,
    input  logic [LANES*ADDR_W-1:0] addr,
    output logic [PW-1:0]           passes
);
    localparam int unsigned BW = $clog2(BANKS);

    // first_use[i]: lane i is the lowest active lane asking for its word
    logic [LANES-1:0] first_use;
    logic [PW-1:0]    bank_cnt [BANKS];

    for (genvar i = 0; i < LANES; i++) begin : g_first
        always_comb begin
            first_use[i] = active[i];
            for (int j = 0; j < i; j++) begin
                if (active[j] && (addr[j*ADDR_W +: ADDR_W] == addr[i*ADDR_W +: ADDR_W]))
                    first_use[i] = 1'b0;
            end
        end
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        always_comb begin
            bank_cnt[b] = '0;
            for (int i = 0; i < LANES; i++) begin
                if (first_use[i] && (addr[i*ADDR_W +: BW] == BW'(b)))
                    bank_cnt[b] = bank_cnt[b] + PW'(1);
            end
        end
    end

    always_comb begin
        logic [PW-1:0] worst;
        worst = '0;
        for (int b = 0; b < BANKS; b++) begin
            if (bank_cnt[b] > worst)
                worst = bank_cnt[b];
        end
        passes = (worst == '0) ? PW'(1) : worst;
    end

endmodule

// File: rtl/bpc_grant_pick.sv
// One pass: each bank picks the word of its lowest pending lane, and every
// pending lane that asks for that word is granted with it.
module bpc_grant_pick #(
    parameter int unsigned LANES  = bpc_pkg::DEF_LANES,
    parameter int unsigned BANKS  = bpc_pkg::DEF_BANKS,
    parameter int unsigned ADDR_W = bpc_pkg::DEF_ADDR_W
) (
    input  logic [LANES-1:0]        pending,
    input  logic [LANES*ADDR_W-1:0] addr,
    output logic [LANES-1:0]        grant
);
    localparam int unsigned BW = $clog2(BANKS);

    // leader[i]: lane i is the lowest pending lane of its bank
    logic [LANES-1:0] leader;

    for (genvar i = 0; i < LANES; i++) begin : g_lead
        always_comb begin
            leader[i] = pending[i];
            for (int j = 0; j < i; j++) begin
                if (pending[j] && (addr[j*ADDR_W +: BW] == addr[i*ADDR_W +: BW]))
                    leader[i] = 1'b0;
            end
        end
    end

    // same word implies same bank, so matching a leader's word is enough
    for (genvar i = 0; i < LANES; i++) begin : g_gnt
        always_comb begin
            grant[i] = 1'b0;
            for (int j = 0; j <= i; j++) begin
                if (leader[j] && (addr[j*ADDR_W +: ADDR_W] == addr[i*ADDR_W +: ADDR_W]))
                    grant[i] = pending[i];
            end
        end
    end

endmodule

// File: rtl/bank_pass_sched.sv
module bank_pass_sched #(
    parameter int unsigned LANES  = bpc_pkg::DEF_LANES,
    parameter int unsigned BANKS  = bpc_pkg::DEF_BANKS,
    parameter int unsigned ADDR_W = bpc_pkg::DEF_ADDR_W,
    localparam int unsigned PW    = bpc_pkg::count_width(LANES)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [LANES-1:0]        req_active,
    input  logic [LANES*ADDR_W-1:0] req_addr,
    output logic                    gnt_valid,
    output logic [LANES-1:0]        gnt_mask,
    output logic                    gnt_last,
    output logic [PW-1:0]           gnt_pass_idx,
    output logic [PW-1:0]           gnt_passes
);
    import bpc_pkg::*;

    bpc_state_e              state_q;
    logic [LANES*ADDR_W-1:0] addr_q;
    logic [LANES-1:0]        pend_q;
    logic [PW-1:0]           passes_q;
    logic [PW-1:0]           idx_q;

    logic [PW-1:0]           passes_in;
    logic [LANES-1:0]        pick;

    bpc_pass_count #(
        .LANES (LANES),
        .BANKS (BANKS),
        .ADDR_W(ADDR_W),
        .PW    (PW)
    ) u_count (
        .active(req_active),
        .addr  (req_addr),
        .passes(passes_in)
    );

    bpc_grant_pick #(
        .LANES (LANES),
        .BANKS (BANKS),
        .ADDR_W(ADDR_W)
    ) u_pick (
        .pending(pend_q),
        .addr   (addr_q),
        .grant  (pick)
    );

    assign req_ready    = (state_q == ST_IDLE);
    assign gnt_valid    = (state_q == ST_SERVE);
    assign gnt_mask     = pick;
    assign gnt_last     = gnt_valid && ((pend_q & ~pick) == '0);
    assign gnt_pass_idx = idx_q;
    assign gnt_passes   = passes_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            addr_q   <= '0;
            pend_q   <= '0;
            passes_q <= '0;
            idx_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        state_q  <= ST_SERVE;
                        addr_q   <= req_addr;
                        pend_q   <= req_active;
                        passes_q <= passes_in;
                        idx_q    <= '0;
                    end
                end
                ST_SERVE: begin
                    pend_q <= pend_q & ~pick;
                    idx_q  <= idx_q + PW'(1);
                    if (gnt_last)
                        state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/bpc_checker.sv
module bpc_checker #(
    parameter int unsigned LANES = bpc_pkg::DEF_LANES,
    parameter int unsigned PW    = bpc_pkg::count_width(LANES)
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [LANES-1:0] req_active,
    input logic             gnt_valid,
    input logic [LANES-1:0] gnt_mask,
    input logic             gnt_last,
    input logic [PW-1:0]    gnt_pass_idx,
    input logic [PW-1:0]    gnt_passes
);
    logic [LANES-1:0] grp_act;
    logic [LANES-1:0] served;

    always_ff @(posedge clk) begin
        if (rst) begin
            grp_act <= '0;
            served  <= '0;
        end else if (req_valid && req_ready) begin
            grp_act <= req_active;
            served  <= '0;
        end else if (gnt_valid) begin
            served  <= served | gnt_mask;
        end
    end

    a_r2_reset_idle: assert property (@(posedge clk)
        rst |=> (req_ready && !gnt_valid));

    a_r3_first_pass: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (gnt_valid && gnt_pass_idx == '0));

    a_r3_closed_busy: assert property (@(posedge clk) disable iff (rst)
        gnt_valid |-> !req_ready);

    a_r4_pass_range: assert property (@(posedge clk) disable iff (rst)
        gnt_valid |-> (gnt_passes != '0 && gnt_pass_idx < gnt_passes));

    a_r6_disjoint: assert property (@(posedge clk) disable iff (rst)
        gnt_valid |-> ((gnt_mask & served) == '0));

    a_r6_complete: assert property (@(posedge clk) disable iff (rst)
        (gnt_valid && gnt_last) |-> ((served | gnt_mask) == grp_act));

    a_r7_no_idle_grant: assert property (@(posedge clk) disable iff (rst)
        gnt_valid |-> ((gnt_mask & ~grp_act) == '0));

    a_r8_last_at_end: assert property (@(posedge clk) disable iff (rst)
        gnt_valid |-> (gnt_last == (gnt_pass_idx == gnt_passes - PW'(1))));

    a_r8_idx_step: assert property (@(posedge clk) disable iff (rst)
        (gnt_valid && !gnt_last) |=>
            (gnt_valid && gnt_pass_idx == $past(gnt_pass_idx) + PW'(1)));

endmodule

bind bank_pass_sched bpc_checker #(.LANES(LANES), .PW(PW)) u_chk (.*);

// File: tb/bank_pass_sched_tb.sv
module bank_pass_sched_tb;
    localparam int unsigned L  = 16;
    localparam int unsigned NB = 16;
    localparam int unsigned AW = 16;
    localparam int unsigned PW = $clog2(L + 1);
    localparam time CLK_PERIOD = 10ns;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [L-1:0]    req_active = '0;
    logic [L*AW-1:0] req_addr = '0;
    logic            gnt_valid;
    logic [L-1:0]    gnt_mask;
    logic            gnt_last;
    logic [PW-1:0]   gnt_pass_idx;
    logic [PW-1:0]   gnt_passes;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_pass_sched #(.LANES(L), .BANKS(NB), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_active(req_active), .req_addr(req_addr),
        .gnt_valid(gnt_valid), .gnt_mask(gnt_mask), .gnt_last(gnt_last),
        .gnt_pass_idx(gnt_pass_idx), .gnt_passes(gnt_passes)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    function automatic logic [AW-1:0] lane_addr(input logic [L*AW-1:0] a, input int i);
        return a[i*AW +: AW];
    endfunction

    // R4 reference: worst distinct-word count over banks, at least one
    function automatic int model_passes(input logic [L-1:0] act, input logic [L*AW-1:0] a);
        int worst = 0;
        for (int b = 0; b < int'(NB); b++) begin
            int n = 0;
            for (int i = 0; i < int'(L); i++) begin
                bit seen = 0;
                if (!act[i] || (int'(lane_addr(a, i)) % int'(NB)) != b) continue;
                for (int j = 0; j < i; j++)
                    if (act[j] && lane_addr(a, j) == lane_addr(a, i)) seen = 1;
                if (!seen) n++;
            end
            if (n > worst) worst = n;
        end
        return (worst == 0) ? 1 : worst;
    endfunction

    // R5 reference: walk banks, take the lowest unserved lane's word
    function automatic logic [L-1:0] model_grant(input logic [L-1:0] pend, input logic [L*AW-1:0] a);
        logic [L-1:0] g = '0;
        for (int b = 0; b < int'(NB); b++) begin
            int lead = -1;
            for (int i = int'(L) - 1; i >= 0; i--)
                if (pend[i] && (int'(lane_addr(a, i)) % int'(NB)) == b) lead = i;
            if (lead >= 0)
                for (int i = 0; i < int'(L); i++)
                    if (pend[i] && lane_addr(a, i) == lane_addr(a, lead)) g[i] = 1'b1;
        end
        return g;
    endfunction

    task automatic run_group(input logic [L-1:0] act, input logic [L*AW-1:0] a,
                             input bit noise, input string tag);
        logic [L-1:0] pend = act;
        int exp_n = model_passes(act, a);
        @(negedge clk);
        chk(req_ready === 1'b1, "R3", {tag, " ready before offer"}, 64'(req_ready), 64'd1);
        req_valid  = 1'b1;
        req_active = act;
        req_addr   = a;
        @(posedge clk);
        for (int k = 0; k <= int'(L); k++) begin
            logic [L-1:0] eg;
            bit el;
            @(negedge clk);
            eg = model_grant(pend, a);
            el = ((pend & ~eg) == '0);
            chk(gnt_valid === 1'b1, "R4", {tag, " valid during pass"}, 64'(gnt_valid), 64'd1);
            chk(req_ready === 1'b0, "R3", {tag, " ready closed while busy"}, 64'(req_ready), 64'd0);
            chk(gnt_mask === eg, "R5", {tag, " grant mask"}, 64'(gnt_mask), 64'(eg));
            chk(gnt_pass_idx === PW'(k), "R8", {tag, " pass index"}, 64'(gnt_pass_idx), 64'(k));
            chk(gnt_passes === PW'(exp_n), "R4", {tag, " pass count"}, 64'(gnt_passes), 64'(exp_n));
            chk(gnt_last === el, "R8", {tag, " last flag"}, 64'(gnt_last), 64'(el));
            pend = pend & ~eg;
            if (noise && !el) begin
                // R10: a fresh offer while busy must not be taken
                req_valid  = 1'b1;
                req_active = L'($urandom);
                req_addr   = {($urandom), ($urandom), ($urandom), ($urandom),
                              ($urandom), ($urandom), ($urandom), ($urandom)};
            end else begin
                req_valid = 1'b0;
            end
            if (el) break;
        end
        @(negedge clk);
        chk(gnt_valid === 1'b0 && req_ready === 1'b1, "R4", {tag, " idle after last pass"},
            64'({gnt_valid, req_ready}), 64'b01);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [L*AW-1:0] a;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready === 1'b1 && gnt_valid === 1'b0, "R2", "in reset",
            64'({req_ready, gnt_valid}), 64'b10);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready === 1'b1 && gnt_valid === 1'b0, "R2", "after reset",
            64'({req_ready, gnt_valid}), 64'b10);

        // R9: consecutive words -> one pass
        for (int i = 0; i < int'(L); i++) a[i*AW +: AW] = AW'(100 + i);
        run_group('1, a, 0, "R9 consecutive");

        // R9: stride 19 is coprime with 16 banks -> one pass
        for (int i = 0; i < int'(L); i++) a[i*AW +: AW] = AW'(7 + 19 * i);
        run_group('1, a, 0, "R9 stride19");

        // R5: all lanes on one word -> broadcast in one pass
        for (int i = 0; i < int'(L); i++) a[i*AW +: AW] = AW'(42);
        run_group('1, a, 0, "R5 broadcast");

        // R1/R4: stride of the bank count -> one bank, sixteen passes in lane order
        for (int i = 0; i < int'(L); i++) a[i*AW +: AW] = AW'(5 + 16 * i);
        run_group('1, a, 0, "R1 stride16");

        // R7: no active lane -> single empty pass
        run_group('0, a, 0, "R7 empty");

        // R7: inactive lane 1 conflicts with lane 0 but is ignored -> one pass
        for (int i = 0; i < int'(L); i++) a[i*AW +: AW] = AW'(200 + i);
        a[1*AW +: AW] = AW'(200 + 16);
        run_group(16'hFFFD, a, 0, "R7 idle conflict");

        // R5/R6: bank 3 holds words 3,19,35; lanes 0,2 share 3, lanes 1,4 share 19
        for (int i = 0; i < int'(L); i++) a[i*AW +: AW] = AW'(i + 64);
        a[0*AW +: AW] = AW'(3);
        a[1*AW +: AW] = AW'(19);
        a[2*AW +: AW] = AW'(3);
        a[3*AW +: AW] = AW'(35);
        a[4*AW +: AW] = AW'(19);
        run_group(16'h001F, a, 0, "R6 mixed");

        // R10: offers held high while busy
        for (int i = 0; i < int'(L); i++) a[i*AW +: AW] = AW'(9 + 32 * (i % 4));
        run_group('1, a, 1, "R10 busy offer");

        // random groups over a small address space so conflicts are common
        for (int n = 0; n < 300; n++) begin
            for (int i = 0; i < int'(L); i++) a[i*AW +: AW] = AW'($urandom_range(0, 63));
            run_group(L'($urandom), a, (n % 5) == 0, "R5 random");
        end

        finish_run();
    end

endmodule